// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 device from power-on to normal operation. A single start pulse launches a fixed list of memory commands, presented one at a time on a valid/ready command port. Each command is held until the downstream port accepts it. A programmable pause separates the first two no-operation commands. Two flags travel with the commands: a DLL-reset flag and an OCD-default flag. A downstream controller folds these flags into the mode-register data it writes. When the last command has been accepted, the block raises a sticky done flag.

The block also works out the system address of every mode-register write. This address depends on where the bank bits sit in the address map. That position is derived from four inputs: the column-width code, the row-width code, the address-decode mode and the bus width. The position is latched when the sequence starts. Each mode-register command then carries a base address with its bank number placed at that position. A 5-bit step index is brought out so the position in the list can be observed.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `cmd_valid`, `done`, `dll_reset` and `ocd_default` are 0 and `step_idx` is 0.
- R2: Once `cmd_valid` is high, it stays high with `cmd_code`, `cmd_bank` and `cmd_addr` unchanged until a rising edge sees `cmd_ready` high. Only that edge moves the sequence on.
- R3: A `start` pulse in idle makes the block issue a NOP (code 1). After that NOP is accepted, `cmd_valid` stays low for exactly `DELAY_CYC` cycles with `step_idx` = 1, and then a second NOP is issued.
- R4: After the second NOP, the commands are a precharge-all (code 2), then extended mode writes (code 5) to bank 2, bank 3 and bank 1, in that order.
- R5: Next comes a mode register set (code 3, bank 0), then a precharge-all, then exactly two refreshes (code 4). `dll_reset` is high during all four of these commands.
- R6: After the second refresh, `dll_reset` goes low and another mode register set (bank 0) is issued.
- R7: Next comes an extended write to bank 1 with `ocd_default` high, then another extended write to bank 1 with `ocd_default` low.
- R8: The list ends with a normal-mode command (code 0) and then a dummy write (code 6) to the base address. `done` rises in the cycle after the dummy write is accepted and stays high. `step_idx` rises by one on each accepted command.
- R9: `bank_offset` = `col_code` + 9, plus `row_code` + 11 when `interleave_sel` is 0, plus 1 when `bus_narrow` is 1 (16-bit bus) or 2 when `bus_narrow` is 0 (32-bit bus). It is latched at start.
- R10: `cmd_addr` = `BASE_ADDR` + (`cmd_bank` << `bank_offset`). Commands that are not mode writes use bank 0.
- R11: A `start` pulse while a sequence runs, or after `done`, has no effect. In particular, it does not change the step or the order of commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only in idle |
| col_code | input | 2 | Column-width code |
| row_code | input | 2 | Row-width code |
| interleave_sel | input | 1 | 1 = interleaved bank decode, 0 = sequential |
| bus_narrow | input | 1 | 1 = 16-bit bus, 0 = 32-bit bus |
| cmd_ready | input | 1 | Command port can accept |
| cmd_valid | output | 1 | Command present |
| cmd_code | output | 4 | Command code |
| cmd_bank | output | 2 | Mode register bank selector |
| cmd_addr | output | ADDR_W | System address of the command |
| dll_reset | output | 1 | DLL-reset flag |
| ocd_default | output | 1 | OCD-default flag |
| done | output | 1 | Sequence complete (sticky) |
| step_idx | output | 5 | Current step index |
| bank_offset | output | 6 | Latched bank bit position |

## Verification
The two functions that can meet in one cycle are a command handshake and a new start request. The bench waits for a cycle in which `cmd_valid` and `cmd_ready` are both high at a step past the pause, and pulses `start` in that same cycle. The check passes if the step index moves up by exactly one and the remaining commands still match the expected queue in order. It fails if the sequence restarts at its first NOP. A handshake arriving while the pause is counting is also covered, because `cmd_ready` toggles throughout the pause with `cmd_valid` low.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;
  typedef enum logic [3:0] {
    CMD_NORMAL = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_PALL   = 4'd2,
    CMD_MRS    = 4'd3,
    CMD_REF    = 4'd4,
    CMD_EMRS   = 4'd5,
    CMD_DWR    = 4'd6
  } cmd_e;

  typedef struct packed {
    cmd_e       code;
    logic [1:0] bank;
    logic       is_wait;
    logic       dll;
    logic       ocd;
    logic       last;
  } step_t;

  localparam int STEP_W    = 5;
  localparam int OFF_W     = 6;
  localparam int LAST_STEP = 15;
endpackage

// File: rtl/ddr2_bank_offset.sv
module ddr2_bank_offset
  import ddr2_init_pkg::*;
#(
  parameter int COL_BASE = 9,
  parameter int ROW_BASE = 11
) (
  input  logic [1:0]       col_code,
  input  logic [1:0]       row_code,
  input  logic             interleave_sel,
  input  logic             bus_narrow,
  output logic [OFF_W-1:0] offset
);
  logic [OFF_W-1:0] col_part, row_part, bus_part;

  always_comb begin
    col_part = OFF_W'(col_code) + OFF_W'(COL_BASE);
    row_part = interleave_sel ? '0 : OFF_W'(row_code) + OFF_W'(ROW_BASE);
    bus_part = bus_narrow ? OFF_W'(1) : OFF_W'(2);
    offset   = col_part + row_part + bus_part;
  end
endmodule

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
  import ddr2_init_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  output step_t             entry
);
  always_comb begin
    entry = '{code: CMD_NOP, bank: 2'd0, is_wait: 1'b0, dll: 1'b0, ocd: 1'b0, last: 1'b0};
    unique case (idx)
      5'd0:  entry.code = CMD_NOP;
      5'd1:  entry.is_wait = 1'b1;
      5'd2:  entry.code = CMD_NOP;
      5'd3:  entry.code = CMD_PALL;
      5'd4:  begin entry.code = CMD_EMRS; entry.bank = 2'd2; end
      5'd5:  begin entry.code = CMD_EMRS; entry.bank = 2'd3; end
      5'd6:  begin entry.code = CMD_EMRS; entry.bank = 2'd1; end
      5'd7:  begin entry.code = CMD_MRS;  entry.dll = 1'b1; end
      5'd8:  begin entry.code = CMD_PALL; entry.dll = 1'b1; end
      5'd9:  begin entry.code = CMD_REF;  entry.dll = 1'b1; end
      5'd10: begin entry.code = CMD_REF;  entry.dll = 1'b1; end
      5'd11: entry.code = CMD_MRS;
      5'd12: begin entry.code = CMD_EMRS; entry.bank = 2'd1; entry.ocd = 1'b1; end
      5'd13: begin entry.code = CMD_EMRS; entry.bank = 2'd1; end
      5'd14: entry.code = CMD_NORMAL;
      5'd15: begin entry.code = CMD_DWR; entry.last = 1'b1; end
      default: entry.is_wait = 1'b1;
    endcase
  end
endmodule

// File: rtl/ddr2_delay_timer.sv
module ddr2_delay_timer #(
  parameter int DELAY_CYC = 25000,
  localparam int CNT_W = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  logic [CNT_W-1:0] cnt;
  logic             active;

  assign expired = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= CNT_W'(DELAY_CYC - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int              DELAY_CYC = 25000,
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        col_code,
  input  logic [1:0]        row_code,
  input  logic              interleave_sel,
  input  logic              bus_narrow,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [3:0]        cmd_code,
  output logic [1:0]        cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              dll_reset,
  output logic              ocd_default,
  output logic              done,
  output logic [4:0]        step_idx,
  output logic [5:0]        bank_offset
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e            st;
  logic [STEP_W-1:0] step_q;
  logic [OFF_W-1:0]  off_c, off_q, off_sel;
  logic [STEP_W-1:0] nxt_idx;
  step_t             nxt;
  logic              in_wait, cur_last, timer_load, timer_exp;
  logic              accept, leave_wait;

  ddr2_bank_offset u_off (
    .col_code(col_code), .row_code(row_code),
    .interleave_sel(interleave_sel), .bus_narrow(bus_narrow), .offset(off_c)
  );

  assign nxt_idx = (st == ST_IDLE) ? '0 : step_q + 1'b1;

  ddr2_step_rom u_rom (.idx(nxt_idx), .entry(nxt));

  assign accept     = (st == ST_RUN) && cmd_valid && cmd_ready;
  assign leave_wait = (st == ST_RUN) && in_wait && timer_exp;
  assign off_sel    = (st == ST_IDLE) ? off_c : off_q;
  assign timer_load = ((st == ST_IDLE && start) || (accept && !cur_last) || leave_wait) && nxt.is_wait;

  ddr2_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(timer_load), .expired(timer_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      step_q      <= '0;
      off_q       <= '0;
      cmd_valid   <= 1'b0;
      cmd_code    <= 4'(CMD_NOP);
      cmd_bank    <= '0;
      cmd_addr    <= BASE_ADDR;
      dll_reset   <= 1'b0;
      ocd_default <= 1'b0;
      in_wait     <= 1'b0;
      cur_last    <= 1'b0;
      done        <= 1'b0;
    end else begin
      if ((st == ST_IDLE && start) || (accept && !cur_last) || leave_wait) begin
        if (st == ST_IDLE) begin
          st    <= ST_RUN;
          off_q <= off_c;
        end
        step_q      <= nxt_idx;
        cmd_valid   <= !nxt.is_wait;
        cmd_code    <= 4'(nxt.code);
        cmd_bank    <= nxt.bank;
        cmd_addr    <= BASE_ADDR + (ADDR_W'(nxt.bank) << off_sel);
        dll_reset   <= nxt.dll;
        ocd_default <= nxt.ocd;
        in_wait     <= nxt.is_wait;
        cur_last    <= nxt.last;
      end else if (accept && cur_last) begin
        st          <= ST_DONE;
        step_q      <= step_q + 1'b1;
        cmd_valid   <= 1'b0;
        dll_reset   <= 1'b0;
        ocd_default <= 1'b0;
        done        <= 1'b1;
      end
    end
  end

  assign step_idx    = step_q;
  assign bank_offset = off_q;

  a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_bank));

  a_r5_refresh_under_dll: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_code == 4'(CMD_REF) |-> dll_reset);

  a_r7_ocd_only_emrs1: assert property (@(posedge clk) disable iff (rst)
    ocd_default |-> cmd_valid && cmd_code == 4'(CMD_EMRS) && cmd_bank == 2'd1);

  a_r8_step_advance: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> step_idx == $past(step_idx) + 5'd1);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !cmd_valid);

  a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    start && step_idx != 5'd0 && !(cmd_valid && cmd_ready) && !in_wait |=> $stable(step_idx));
endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
  localparam int DLY = 20;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 0, rst = 1, start = 0;
  logic [1:0] col_code = 0, row_code = 0;
  logic interleave_sel = 0, bus_narrow = 0, cmd_ready = 0;
  logic cmd_valid, dll_reset, ocd_default, done;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [31:0] cmd_addr;
  logic [4:0] step_idx;
  logic [5:0] bank_offset;

  int checks = 0, errors = 0, wait_cnt = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [40:0] q[$];

  always #4 clk = ~clk;

  ddr2_init_seq #(.DELAY_CYC(DLY), .ADDR_W(32), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst(rst), .start(start), .col_code(col_code), .row_code(row_code),
    .interleave_sel(interleave_sel), .bus_narrow(bus_narrow), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .dll_reset(dll_reset), .ocd_default(ocd_default), .done(done),
    .step_idx(step_idx), .bank_offset(bank_offset));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [40:0] item(input logic [3:0] c, input logic [1:0] b, input logic d,
                                       input logic o, input int off);
    logic [31:0] a;
    a = BASE + (32'(b) << off);
    return {c, b, d, o, a};
  endfunction

  task automatic push_all(input int off);
    q.push_back(item(1, 0, 0, 0, off)); // R3 NOP
    q.push_back(item(1, 0, 0, 0, off)); // R3 NOP after delay
    q.push_back(item(2, 0, 0, 0, off)); // R4
    q.push_back(item(5, 2, 0, 0, off));
    q.push_back(item(5, 3, 0, 0, off));
    q.push_back(item(5, 1, 0, 0, off));
    q.push_back(item(3, 0, 1, 0, off)); // R5
    q.push_back(item(2, 0, 1, 0, off));
    q.push_back(item(4, 0, 1, 0, off));
    q.push_back(item(4, 0, 1, 0, off));
    q.push_back(item(3, 0, 0, 0, off)); // R6
    q.push_back(item(5, 1, 0, 1, off)); // R7
    q.push_back(item(5, 1, 0, 0, off));
    q.push_back(item(0, 0, 0, 0, off)); // R8
    q.push_back(item(6, 0, 0, 0, off));
  endtask

  // ready changes only just after a rising edge
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready <= lfsr[0] | lfsr[2];
  end

  // monitor: compare each accepted command with the queue head
  always @(negedge clk) begin
    if (!rst) begin
      if (step_idx == 5'd1 && !cmd_valid) wait_cnt++;
      if (cmd_valid && cmd_ready) begin
        logic [40:0] got;
        got = {cmd_code, cmd_bank, dll_reset, ocd_default, cmd_addr};
        if (q.size() == 0) chk(0, "R8 unexpected command", 64'(got), 0);
        else begin
          logic [40:0] e;
          e = q.pop_front();
          chk(got == e, "R4/R5/R6/R7/R10 command", 64'(got), 64'(e));
        end
      end
      if (done && q.size() != 0) chk(0, "R8 done early", 64'(q.size()), 0);
    end
  end

  task automatic run(input logic [1:0] cc, input logic [1:0] rc, input logic il, input logic nb,
                     input bit poke);
    int off;
    off = int'(cc) + 9 + (il ? 0 : int'(rc) + 11) + (nb ? 1 : 2);
    col_code = cc; row_code = rc; interleave_sel = il; bus_narrow = nb;
    push_all(off);
    wait_cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(bank_offset == 6'(off), "R9 offset", 64'(bank_offset), 64'(off));
    chk(cmd_valid && cmd_code == 4'd1, "R3 first NOP", 64'(cmd_code), 1);
    if (poke) begin
      int s;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (cmd_valid && cmd_ready && step_idx >= 5'd5) break;
      end
      s = step_idx;
      start = 1;
      @(negedge clk); start = 0;
      chk(step_idx == 5'(s + 1), "R11 start during handshake", 64'(step_idx), 64'(s + 1));
    end
    for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, "R8 done reached", 64'(done), 1);
    chk(q.size() == 0, "R8 all commands issued", 64'(q.size()), 0);
    chk(wait_cnt == DLY, "R3 delay length", 64'(wait_cnt), 64'(DLY));
    chk(step_idx == 5'd16, "R8 final step", 64'(step_idx), 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done && step_idx == 0 && !dll_reset && !ocd_default, "R1 in reset",
        64'({cmd_valid, done, step_idx}), 0);
    rst = 0;
    @(negedge clk);
    chk(!cmd_valid && !done && step_idx == 0, "R1 after release", 64'({cmd_valid, done, step_idx}), 0);
    run(2'd0, 2'd0, 1'b1, 1'b1, 0);    // offset 10
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk(!done && !cmd_valid, "R1 re-reset", 64'(done), 0);
    run(2'd2, 2'd1, 1'b0, 1'b0, 1);    // offset 25, start poked mid-run
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    run(2'd3, 2'd3, 1'b0, 1'b1, 0);    // offset 27
    start = 1; @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk(done && !cmd_valid && step_idx == 5'd16, "R11 start after done", 64'({done, cmd_valid, step_idx}),
        64'({1'b1, 1'b0, 5'd16}));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule